// File: doc/BRIEF.md
# Packet Command PIO Read Sequencer

This block is the device side of a packet-style storage command carried out in programmed I/O mode. The host selects a device, programs a per-burst byte limit into two byte-wide task-file registers and writes the packet command code. After a short busy period the device asks for a 12-byte command packet, delivered as six 16-bit writes to the data port. When the packet is a block read, the device returns the requested blocks through 16-bit data-port reads, split into bursts no larger than the programmed limit.

Every burst is announced by an interrupt. While the burst is open, the byte count the device chose for it can be read back through the limit registers. After the last burst a final interrupt marks completion. Reading the status register clears a pending interrupt. The media is modelled by a pattern generator: every 16-bit word carries the low bits of its own global word index. The bench can therefore predict every data word without any storage.

Status register layout (address 7 on read): bit 7 busy, bit 6 ready, bit 5 device fault (always 0), bit 3 data request, bit 0 error; all other bits read 0.

Top module: `pkt_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40 (ready only), the interrupt output is low and a data-port read returns 0.
- R2: Writing 0xA0 to address 7 while idle, with bit 4 of the device register (address 6) clear, shows busy (status 0xC0) for BUSY_CYC cycles and then status 0x48 while the packet is awaited. Any other command code, or a selected device 1 (bit 4 set), is ignored and status stays 0x40 with no interrupt.
- R3: The packet is taken as six data-port words, each carrying byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Byte 0 is the operation code (0x28 = block read), bytes 2..5 are the start block (most significant byte first) and bytes 7..8 are the block count (most significant byte first). A block is BLOCK_BYTES (2048) bytes.
- R4: The byte limit is written as a low byte at address 4 and a high byte at address 5. Each burst moves the smaller of the remaining bytes and the limit rounded down to even; a limit below 2 acts as 2.
- R5: Before each burst the interrupt rises, and during the burst status reads 0x48. Busy and data request are never set together.
- R6: While a burst is open, addresses 4 and 5 read back the byte count of that burst (low byte, high byte). Otherwise they read back the programmed limit.
- R7: After the last word of the last burst the device is busy briefly, then raises a completion interrupt and status reads 0x40. A block count of 0 completes this way with no data phase.
- R8: A read of the status register clears a pending interrupt on the next cycle.
- R9: Data-port reads made outside a burst return 0 and do not advance the data. Data-port writes made outside the packet phase are ignored and do not shift the packet capture.
- R10: A packet whose operation code is not 0x28 ends with a completion interrupt, status 0x41 (error set) and no data phase. The error bit clears when the next packet command is accepted.
- R11: Word k of a transfer, counted from 0, is (start_block * BLOCK_BYTES/2 + k) mod 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Task-file register write strobe |
| regRdEn | input | 1 | Task-file register read strobe |
| regAddr | input | 3 | Task-file register address |
| regWrData | input | 8 | Task-file write data |
| regRdData | output | 8 | Task-file read data (combinational) |
| dataWrEn | input | 1 | Data-port write strobe |
| dataWrData | input | 16 | Data-port write word |
| dataRdEn | input | 1 | Data-port read strobe; consumes the word shown |
| dataRdData | output | 16 | Data-port read word (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that busy and data request never overlap, that an error never coexists with a data request, that each burst opens with the interrupt already raised and an even, nonzero byte count, that an accepted packet command turns busy at once, that a status read outside busy leaves the interrupt low, and that the data port reads zero outside a burst. Only the bench scenarios can show the burst sizes for even, odd and tiny limits, the read-back of each burst's count, the exact data words for several start blocks, zero-length and bad-opcode packets, and that ignored commands and stray data-port accesses leave no trace.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam logic [2:0] ADDR_LIM_LO = 3'd4;
  localparam logic [2:0] ADDR_LIM_HI = 3'd5;
  localparam logic [2:0] ADDR_DEVSEL = 3'd6;
  localparam logic [2:0] ADDR_CMDSTAT = 3'd7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMDBSY,
    S_PKT,
    S_SETTLE,
    S_XFER
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrPkt;
    logic capPkt;
    logic startXfer;
    logic startBurst;
    logic popWord;
  } dpCtrl_t;
endpackage

// File: rtl/pio_seq_datapath.sv
module pio_seq_datapath
  import pio_seq_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 2048,
  parameter logic [7:0]  OP_READ     = 8'h28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  dpCtrl_t     ctl,
  input  logic        tfWrEn,
  input  logic [2:0]  tfAddr,
  input  logic [7:0]  tfData,
  input  logic [15:0] pktWord,
  input  logic        inXfer,
  output logic        pktLast,
  output logic        opOk,
  output logic        remZero,
  output logic        burstLast,
  output logic        devSel1,
  output logic [7:0]  devRd,
  output logic [15:0] limitRd,
  output logic [15:0] burstBytes,
  output logic [15:0] dataWord
);
  localparam int unsigned WPB    = BLOCK_BYTES / 2;
  localparam int unsigned WB_W   = $clog2(WPB);
  localparam int unsigned BLK_SH = $clog2(BLOCK_BYTES);
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned LBA_W  = 32;
  localparam int unsigned REM_W  = CNT_W + BLK_SH;

  logic [15:0]      limitReg;
  logic [7:0]       devReg;
  logic [2:0]       pktIdx;
  logic [7:0]       opcode;
  logic [LBA_W-1:0] lba;
  logic [CNT_W-1:0] blkCnt;
  logic [REM_W-1:0] remBytes;
  logic [14:0]      wordsLeft;
  logic [LBA_W-1:0] blkAddr;
  logic [WB_W-1:0]  wordInBlk;
  logic [15:0]      limEff;
  logic [15:0]      burstNow;
  logic [LBA_W+WB_W-1:0] globalIdx;

  always_comb begin
    limEff = (limitReg < 16'd2) ? 16'd2 : {limitReg[15:1], 1'b0};
    if (remBytes < REM_W'(limEff)) burstNow = remBytes[15:0];
    else                           burstNow = limEff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limitReg   <= '0;
      devReg     <= '0;
      pktIdx     <= '0;
      opcode     <= '0;
      lba        <= '0;
      blkCnt     <= '0;
      remBytes   <= '0;
      burstBytes <= '0;
      wordsLeft  <= '0;
      blkAddr    <= '0;
      wordInBlk  <= '0;
    end else begin
      if (tfWrEn) begin
        case (tfAddr)
          ADDR_LIM_LO: limitReg[7:0]  <= tfData;
          ADDR_LIM_HI: limitReg[15:8] <= tfData;
          ADDR_DEVSEL: devReg         <= tfData;
          default: ;
        endcase
      end
      if (ctl.clrPkt) begin
        pktIdx <= '0;
      end else if (ctl.capPkt) begin
        pktIdx <= pktIdx + 3'd1;
        case (pktIdx)
          3'd0: opcode       <= pktWord[7:0];
          3'd1: lba[31:16]   <= {pktWord[7:0], pktWord[15:8]};
          3'd2: lba[15:0]    <= {pktWord[7:0], pktWord[15:8]};
          3'd3: blkCnt[15:8] <= pktWord[15:8];
          3'd4: blkCnt[7:0]  <= pktWord[7:0];
          default: ;
        endcase
      end
      if (ctl.startXfer) begin
        remBytes  <= {blkCnt, BLK_SH'(0)};
        blkAddr   <= lba;
        wordInBlk <= '0;
      end else if (ctl.startBurst) begin
        burstBytes <= burstNow;
        wordsLeft  <= burstNow[15:1];
        remBytes   <= remBytes - REM_W'(burstNow);
      end else if (ctl.popWord) begin
        wordsLeft <= wordsLeft - 15'd1;
        if (wordInBlk == WB_W'(WPB - 1)) begin
          wordInBlk <= '0;
          blkAddr   <= blkAddr + 1'b1;
        end else begin
          wordInBlk <= wordInBlk + 1'b1;
        end
      end
    end
  end

  assign globalIdx = {blkAddr, wordInBlk};
  assign pktLast   = (pktIdx == 3'd5);
  assign opOk      = (opcode == OP_READ);
  assign remZero   = (remBytes == '0);
  assign burstLast = (wordsLeft == 15'd1);
  assign devSel1   = devReg[4];
  assign devRd     = devReg;
  assign limitRd   = inXfer ? burstBytes : limitReg;
  assign dataWord  = inXfer ? globalIdx[15:0] : 16'h0000;
endmodule

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_seq_pkg::*;
#(
  parameter int unsigned BUSY_CYC   = 2,
  parameter logic [7:0]  CMD_PACKET = 8'hA0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdWr,
  input  logic [7:0] cmdByte,
  input  logic       devSel1,
  input  logic       statusRd,
  input  logic       dataWr,
  input  logic       dataRd,
  input  logic       pktLast,
  input  logic       opOk,
  input  logic       remZero,
  input  logic       burstLast,
  output dpCtrl_t    ctl,
  output logic       bsy,
  output logic       drq,
  output logic       err,
  output logic       irq,
  output logic       inXfer
);
  localparam int unsigned BC_W = $clog2(BUSY_CYC + 1);

  seqState_t       state, nextState;
  logic [BC_W-1:0] busyCnt;
  logic            busyDone;
  logic            accept, setIrq, setErr;

  assign busyDone = (busyCnt == '0);

  always_comb begin
    nextState = state;
    ctl       = '0;
    accept    = 1'b0;
    setIrq    = 1'b0;
    setErr    = 1'b0;
    case (state)
      S_IDLE: begin
        if (cmdWr && cmdByte == CMD_PACKET && !devSel1) begin
          accept     = 1'b1;
          ctl.clrPkt = 1'b1;
          nextState  = S_CMDBSY;
        end
      end
      S_CMDBSY: if (busyDone) nextState = S_PKT;
      S_PKT: begin
        if (dataWr) begin
          ctl.capPkt = 1'b1;
          if (pktLast) begin
            ctl.startXfer = 1'b1;
            nextState     = S_SETTLE;
          end
        end
      end
      S_SETTLE: begin
        if (busyDone) begin
          setIrq = 1'b1;
          if (!opOk) begin
            setErr    = 1'b1;
            nextState = S_IDLE;
          end else if (remZero) begin
            nextState = S_IDLE;
          end else begin
            ctl.startBurst = 1'b1;
            nextState      = S_XFER;
          end
        end
      end
      S_XFER: begin
        if (dataRd) begin
          ctl.popWord = 1'b1;
          if (burstLast) nextState = S_SETTLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      busyCnt <= '0;
      irq     <= 1'b0;
      err     <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state && (nextState == S_CMDBSY || nextState == S_SETTLE))
        busyCnt <= BC_W'(BUSY_CYC - 1);
      else if (!busyDone)
        busyCnt <= busyCnt - 1'b1;
      if (setIrq)                  irq <= 1'b1;
      else if (statusRd || accept) irq <= 1'b0;
      if (accept)      err <= 1'b0;
      else if (setErr) err <= 1'b1;
    end
  end

  assign bsy    = (state == S_CMDBSY) || (state == S_SETTLE);
  assign drq    = (state == S_PKT) || (state == S_XFER);
  assign inXfer = (state == S_XFER);
endmodule

// File: rtl/pkt_pio_seq.sv
module pkt_pio_seq
  import pio_seq_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 2048,
  parameter int unsigned BUSY_CYC    = 2,
  parameter logic [7:0]  CMD_PACKET  = 8'hA0,
  parameter logic [7:0]  OP_READ     = 8'h28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        dataWrEn,
  input  logic [15:0] dataWrData,
  input  logic        dataRdEn,
  output logic [15:0] dataRdData,
  output logic        irq
);
  dpCtrl_t     ctl;
  logic        stBsy, stDrq, stErr, inXfer;
  logic        pktLast, opOk, remZero, burstLast, devSel1;
  logic [7:0]  devRd;
  logic [15:0] limitRd, burstBytes;
  logic        statusRd, cmdWr;

  assign statusRd = regRdEn && (regAddr == ADDR_CMDSTAT);
  assign cmdWr    = regWrEn && (regAddr == ADDR_CMDSTAT);

  pio_seq_ctrl #(.BUSY_CYC(BUSY_CYC), .CMD_PACKET(CMD_PACKET)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdWr(cmdWr), .cmdByte(regWrData),
    .devSel1(devSel1), .statusRd(statusRd), .dataWr(dataWrEn),
    .dataRd(dataRdEn), .pktLast(pktLast), .opOk(opOk), .remZero(remZero),
    .burstLast(burstLast), .ctl(ctl), .bsy(stBsy), .drq(stDrq),
    .err(stErr), .irq(irq), .inXfer(inXfer)
  );

  pio_seq_datapath #(.BLOCK_BYTES(BLOCK_BYTES), .OP_READ(OP_READ)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .tfWrEn(regWrEn),
    .tfAddr(regAddr), .tfData(regWrData), .pktWord(dataWrData),
    .inXfer(inXfer), .pktLast(pktLast), .opOk(opOk), .remZero(remZero),
    .burstLast(burstLast), .devSel1(devSel1), .devRd(devRd),
    .limitRd(limitRd), .burstBytes(burstBytes), .dataWord(dataRdData)
  );

  always_comb begin
    case (regAddr)
      ADDR_LIM_LO:  regRdData = limitRd[7:0];
      ADDR_LIM_HI:  regRdData = limitRd[15:8];
      ADDR_DEVSEL:  regRdData = devRd;
      ADDR_CMDSTAT: regRdData = {stBsy, 1'b1, 1'b0, 1'b0, stDrq, 2'b00, stErr};
      default:      regRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/pio_seq_checker.sv
module pio_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [2:0]  regAddr,
  input logic [7:0]  regWrData,
  input logic [15:0] dataRdData,
  input logic        irq,
  input logic        bsy,
  input logic        drq,
  input logic        err,
  input logic        inXfer,
  input logic        devSel1,
  input logic [15:0] burstBytes
);
  AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq)); // R5

  AST_XFER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inXfer) |-> irq); // R5

  AST_BURST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    inXfer |-> (burstBytes[0] == 1'b0 && burstBytes != 16'd0)); // R4

  AST_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == 3'd7 && regWrData == 8'hA0 && !bsy && !drq && !devSel1)
      |=> bsy); // R2

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && regAddr == 3'd7 && !bsy) |=> !irq); // R8

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !inXfer |-> dataRdData == 16'h0000); // R9

  AST_ERR_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !drq); // R10
endmodule

bind pkt_pio_seq pio_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .dataRdData(dataRdData),
  .irq(irq), .bsy(stBsy), .drq(stDrq), .err(stErr), .inXfer(inXfer),
  .devSel1(devSel1), .burstBytes(burstBytes)
);

// File: tb/pkt_pio_seq_bench.sv
`timescale 1ns/1ps
module pkt_pio_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        dataWrEn = 1'b0, dataRdEn = 1'b0;
  logic [15:0] dataWrData = '0;
  logic [15:0] dataRdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pkt_pio_seq u_pkt_pio_seq (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .dataRdEn(dataRdEn),
    .dataRdData(dataRdData), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    #1 v = regRdData;
    @(posedge clk); #1 regRdEn = 1'b0;
  endtask

  task automatic wrData(input logic [15:0] d);
    @(negedge clk); dataWrEn = 1'b1; dataWrData = d;
    @(posedge clk); #1 dataWrEn = 1'b0;
  endtask

  task automatic rdData(output logic [15:0] v);
    @(negedge clk); dataRdEn = 1'b1;
    #1 v = dataRdData;
    @(posedge clk); #1 dataRdEn = 1'b0;
  endtask

  task automatic waitIrq(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1; break; end
    end
  endtask

  // full packet command: returns after completion
  task automatic runXfer(input logic [7:0] op, input int lba, input int cnt, input int lim);
    logic [7:0]  s, lo, hi;
    logic [15:0] w;
    bit seen;
    int limEff, rem, b, g;
    wrReg(3'd6, 8'h00);
    wrReg(3'd4, lim[7:0]);
    wrReg(3'd5, lim[15:8]);
    wrReg(3'd7, 8'hA0);
    rdReg(3'd7, s);
    chk(s == 8'hC0, "R2 busy after command", s, 8'hC0);
    for (int i = 0; i < 50 && s[7]; i++) rdReg(3'd7, s);
    chk(s == 8'h48, "R2 awaiting packet", s, 8'h48);
    // R3 packet byte layout
    wrData({8'h00, op});
    wrData({lba[23:16], lba[31:24]});
    wrData({lba[7:0], lba[15:8]});
    wrData({cnt[15:8], 8'h00});
    wrData({8'h00, cnt[7:0]});
    wrData(16'h0000);
    if (op != 8'h28) begin
      waitIrq(seen);
      chk(seen, "R10 interrupt on bad opcode", seen, 1);
      rdReg(3'd7, s);
      chk(s == 8'h41, "R10 error status", s, 8'h41);
      return;
    end
    limEff = (lim < 2) ? 2 : (lim & 32'hFFFE);
    rem = cnt * 2048;
    g = 0;
    while (rem > 0) begin
      b = (rem < limEff) ? rem : limEff;
      waitIrq(seen);
      chk(seen, "R5 interrupt before burst", seen, 1);
      rdReg(3'd7, s);
      chk(s == 8'h48, "R5 burst status", s, 8'h48);
      #1 chk(irq == 1'b0, "R8 status read clears irq", irq, 0);
      rdReg(3'd4, lo);
      rdReg(3'd5, hi);
      chk({hi, lo} == b[15:0], "R4 R6 burst byte count", {hi, lo}, b);
      for (int k = 0; k < b / 2; k++) begin
        logic [15:0] e;
        e = 16'((lba * 1024 + g) & 32'hFFFF);
        rdData(w);
        chk(w == e, "R11 data word", w, e);
        g++;
      end
      rem -= b;
    end
    waitIrq(seen);
    chk(seen, "R7 completion interrupt", seen, 1);
    rdReg(3'd7, s);
    chk(s == 8'h40, "R7 final status", s, 8'h40);
    #1 chk(irq == 1'b0, "R8 irq cleared after completion", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  s;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdReg(3'd7, s);
    chk(s == 8'h40, "R1 reset status", s, 8'h40);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    rdData(w);
    chk(w == 16'h0, "R1 R9 reset data port", w, 0);

    runXfer(8'h28, 7, 1, 5120);   // single burst
    runXfer(8'h28, 0, 5, 5120);   // two full bursts
    runXfer(8'h28, 3, 3, 5121);   // odd limit: R4
    runXfer(8'h28, 100, 1, 1000); // short last burst
    runXfer(8'h28, 5, 0, 5120);   // zero count: R7
    runXfer(8'h28, 2, 1, 1);      // limit below 2: R4

    // R10 bad opcode, then recovery clears error
    runXfer(8'h12, 4, 1, 5120);
    rdData(w);
    chk(w == 16'h0, "R9 read after error", w, 0);
    runXfer(8'h28, 9, 1, 4096);
    rdReg(3'd7, s);
    chk(s == 8'h40, "R10 error cleared by next command", s, 8'h40);

    // R2 non-packet command ignored
    wrReg(3'd7, 8'hEC);
    repeat (4) @(negedge clk);
    rdReg(3'd7, s);
    chk(s == 8'h40, "R2 other command ignored", s, 8'h40);
    chk(irq == 1'b0, "R2 no irq on other command", irq, 0);

    // R2 device 1 selected ignored
    wrReg(3'd6, 8'h10);
    wrReg(3'd7, 8'hA0);
    rdReg(3'd7, s);
    chk(s == 8'h40, "R2 device 1 ignored", s, 8'h40);

    // R9 stray data accesses while idle leave no trace
    wrData(16'h1234);
    wrData(16'h0028);
    rdData(w);
    chk(w == 16'h0, "R9 idle read zero", w, 0);
    runXfer(8'h28, 11, 1, 2048);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule